// File: doc/BRIEF.md
# Register-Write Command Ring Controller

This block sits between a host port that issues register writes and the register port of a drawing engine. It hides from software the fact that the engine may be busy. A write goes straight to the engine when the engine reports idle and nothing is waiting. In every other case the address and data are packed into a 64-bit entry and appended to a circular buffer in memory. Queued entries are replayed to the engine, oldest first, in the cycles in which the engine reports idle.

The ring is bounded by two configuration registers: a start address and an end address. The end register also carries a 2-bit mode: off, on, or drain-then-off. Entries pass through a small write staging FIFO on their way to memory and a small read staging FIFO on the way back, so memory traffic comes in runs rather than single accesses. When the memory part of the ring is empty and the engine is idle, a staged entry is handed to the engine directly and never visits memory.

Top module: `cmd_ring_ctrl`

## Requirements
- R1: After reset the mode is off (00), host_ready is 1, eng_we and mem_req are 0, and both configuration registers read as 0.
- R2: In mode off, every accepted host write whose address is not a configuration register appears on eng_we/eng_addr/eng_data in the cycle after acceptance, whatever eng_idle is. No memory request is made.
- R3: In mode on, a host write accepted while eng_idle is 1 and no entry is queued anywhere reaches the engine in the next cycle and causes no memory write.
- R4: In mode on, any other buffered host write becomes a 64-bit entry {data[31:0], addr[31:0]}, with the address in bits 31:0. It is written to memory at the ring write address, and the engine sees nothing until draining.
- R5: Queued entries reach the engine in acceptance order, at most one per cycle, and only in cycles after a cycle in which eng_idle was 1. Entries still in the write staging FIFO are sent only after every older entry in memory.
- R6: Ring addresses advance in steps of 8 bytes and stay in [start, end). After the address end-8 the next one is start.
- R7: The ring is full when the write address plus 8 (after wrap) equals the read address. No memory write is made while it is full. host_ready drops to 0 for a buffered write while the write staging FIFO is full, and no entry is lost. With default parameters and an 8-entry ring, 15 entries fit while the engine is busy.
- R8: A write to the start register sets both ring pointers to the new start address and discards every queued entry. None of them ever reaches the engine.
- R9: A write flagged host_unbuf reaches the engine in the next cycle, even while the engine is busy or entries are queued. A write to a configuration register address (start at 32'h0000_1000, end at 32'h0000_1004) never reaches the engine or memory.
- R10: Mode 10 keeps draining as in mode on. In the cycle after the ring and both FIFOs become empty, the mode reads 00.
- R11: A write of mode code 11 leaves the mode field unchanged; the end address in that write still takes effect.
- R12: Configuration read: csr_sel=0 returns {8'b0, start}, and csr_sel=1 returns {mode[1:0], 6'b0, end}. Address bits 2:0 are forced to 0 on write, and all reserved bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_valid | input | 1 | Host write request |
| host_ready | output | 1 | Host write accepted this cycle when high |
| host_addr | input | 32 | Host register address |
| host_data | input | 32 | Host register data |
| host_unbuf | input | 1 | Write must bypass the ring |
| csr_sel | input | 1 | Configuration read select (0 start, 1 end/mode) |
| csr_rdata | output | 32 | Configuration read data |
| eng_idle | input | 1 | Engine can take a write |
| eng_we | output | 1 | Engine register write strobe |
| eng_addr | output | 32 | Engine register address |
| eng_data | output | 32 | Engine register data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | MEM_AW | Byte address of the entry |
| mem_wdata | output | 64 | Entry to write |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data returned, in request order |
| mem_rdata | input | 64 | Returned entry |

## Verification
A direct write (off mode, idle-and-empty, unbufferable) is due on the engine port one cycle after the accepting edge. The bench samples it at the falling edge that follows that edge. Configuration reads are combinational and are sampled one settle delay after csr_sel changes. Queued traffic and drain-then-off take a variable number of cycles, so the bench waits a fixed, generous number of cycles before it compares the engine log, memory contents and write count with the expected ordered list. The full-ring stall is checked by settling the ring first and then sampling host_ready within the same low clock phase in which the next write is presented.

// File: rtl/crc_pkg.sv
package crc_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_ON    = 2'b01,
        MODE_FLUSH = 2'b10,
        MODE_RSVD  = 2'b11
    } mode_e;
endpackage

// File: rtl/crc_fifo.sv
module crc_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fst_t;

    fst_t st_q, st_d;
    logic [W-1:0] slots [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        st_d    = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wp = bump(st_q.wp);
            if (do_pop)  st_d.rp = bump(st_q.rp);
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!flush && do_push) slots[st_q.wp] <= wdata;
    end

    assign rdata = slots[st_q.rp];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == CW'(DEPTH));
endmodule

// File: rtl/crc_ring_ptr.sv
module crc_ring_ptr #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] ptr_nxt
);
    typedef struct packed {
        logic [AW-1:0] p;
    } pst_t;

    pst_t st_q, st_d;
    logic [AW-1:0] step;

    always_comb begin
        step    = st_q.p + AW'(8);
        ptr_nxt = (step == hi) ? lo : step;
        st_d    = st_q;
        if (load)     st_d.p = load_val;
        else if (adv) st_d.p = ptr_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr = st_q.p;
endmodule

// File: rtl/cmd_ring_ctrl.sv
module cmd_ring_ctrl
    import crc_pkg::*;
#(
    parameter int          MEM_AW     = 24,
    parameter int          FIFO_DEPTH = 4,
    parameter logic [31:0] CSR_START  = 32'h0000_1000,
    parameter logic [31:0] CSR_END    = 32'h0000_1004,
    localparam int         CW         = $clog2(FIFO_DEPTH + 1),
    localparam int         ENT_W      = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic [31:0]       host_addr,
    input  logic [31:0]       host_data,
    input  logic              host_unbuf,
    input  logic              csr_sel,
    output logic [31:0]       csr_rdata,
    input  logic              eng_idle,
    output logic              eng_we,
    output logic [31:0]       eng_addr,
    output logic [31:0]       eng_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [ENT_W-1:0]  mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [ENT_W-1:0]  mem_rdata
);
    typedef struct packed {
        mode_e             mode;
        logic [MEM_AW-1:0] lo;
        logic [MEM_AW-1:0] hi;
        logic [CW-1:0]     infl;
        logic [CW-1:0]     disc;
        logic              ewe;
        logic [31:0]       ea;
        logic [31:0]       ed;
    } st_t;

    st_t st_q, st_d;

    logic [MEM_AW-1:0] wptr, wptr_nxt, rptr, rptr_nxt, cfg_addr;
    logic [MEM_AW-1:0] cfg_lo, cfg_hi;
    logic [1:0]        mode_now;
    logic [ENT_W-1:0]  wf_head, rf_head;
    logic [CW-1:0]     wf_cnt, rf_cnt;
    logic [CW:0]       rd_occ;
    logic wf_full, rf_full_unused;
    logic is_start, is_end, is_csr, active, mem_empty, all_empty, ring_full;
    logic direct_cls, fire, host_eng, host_q, start_wr, end_wr;
    logic can_drain, rf_pop, wf_bypass, mem_wr, mem_rd, wr_acc, rd_acc;
    logic wf_pop, rf_push, rv_drop;

    assign cfg_lo   = st_q.lo;
    assign cfg_hi   = st_q.hi;
    assign mode_now = st_q.mode;
    assign cfg_addr = {host_data[MEM_AW-1:3], 3'b000};

    always_comb begin
        is_start   = (host_addr == CSR_START);
        is_end     = (host_addr == CSR_END);
        is_csr     = is_start || is_end;
        active     = (st_q.mode == MODE_ON) || (st_q.mode == MODE_FLUSH);
        mem_empty  = (wptr == rptr) && (st_q.infl == '0) && (rf_cnt == '0);
        all_empty  = mem_empty && (wf_cnt == '0);
        ring_full  = (wptr_nxt == rptr);
        direct_cls = is_csr || host_unbuf || !active || (eng_idle && all_empty);
        host_ready = direct_cls || !wf_full;
        fire       = host_valid && host_ready;
        host_eng   = fire && direct_cls && !is_csr;
        host_q     = fire && !direct_cls;
        start_wr   = fire && is_start;
        end_wr     = fire && is_end;

        can_drain  = active && eng_idle && !(fire && direct_cls);
        rf_pop     = can_drain && (rf_cnt != '0);
        wf_bypass  = can_drain && mem_empty && (wf_cnt != '0);
        mem_wr     = active && !start_wr && (wf_cnt != '0) && !wf_bypass && !ring_full;
        rd_occ     = {1'b0, rf_cnt} + {1'b0, st_q.infl};
        mem_rd     = active && !start_wr && !mem_wr && (wptr != rptr)
                     && (rd_occ < (CW + 1)'(FIFO_DEPTH));
        wr_acc     = mem_wr && mem_gnt;
        rd_acc     = mem_rd && mem_gnt;
        wf_pop     = wr_acc || wf_bypass;
        rv_drop    = mem_rvalid && (st_q.disc != '0);
        rf_push    = mem_rvalid && !rv_drop && !start_wr;

        st_d      = st_q;
        st_d.infl = st_q.infl + CW'(rd_acc) - CW'(mem_rvalid);
        if (start_wr) begin
            st_d.lo   = cfg_addr;
            st_d.disc = st_q.infl - CW'(mem_rvalid);
        end else begin
            st_d.disc = st_q.disc - CW'(rv_drop);
        end
        if (end_wr) begin
            st_d.hi = cfg_addr;
            if (host_data[31:30] != MODE_RSVD) st_d.mode = mode_e'(host_data[31:30]);
        end else if (st_q.mode == MODE_FLUSH && all_empty && !host_q) begin
            st_d.mode = MODE_OFF;
        end

        st_d.ewe = host_eng || rf_pop || wf_bypass;
        if (host_eng) begin
            st_d.ea = host_addr;
            st_d.ed = host_data;
        end else if (rf_pop) begin
            st_d.ea = rf_head[31:0];
            st_d.ed = rf_head[63:32];
        end else if (wf_bypass) begin
            st_d.ea = wf_head[31:0];
            st_d.ed = wf_head[63:32];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_OFF, default: '0};
        else        st_q <= st_d;
    end

    crc_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) i_wfifo (
        .clk(clk), .rst_n(rst_n), .flush(start_wr), .push(host_q),
        .wdata({host_data, host_addr}), .pop(wf_pop), .rdata(wf_head),
        .count(wf_cnt), .full(wf_full)
    );

    crc_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) i_rfifo (
        .clk(clk), .rst_n(rst_n), .flush(start_wr), .push(rf_push),
        .wdata(mem_rdata), .pop(rf_pop), .rdata(rf_head),
        .count(rf_cnt), .full(rf_full_unused)
    );

    crc_ring_ptr #(.AW(MEM_AW)) i_wptr (
        .clk(clk), .rst_n(rst_n), .load(start_wr), .load_val(cfg_addr),
        .adv(wr_acc), .lo(st_q.lo), .hi(st_q.hi), .ptr(wptr), .ptr_nxt(wptr_nxt)
    );

    crc_ring_ptr #(.AW(MEM_AW)) i_rptr (
        .clk(clk), .rst_n(rst_n), .load(start_wr), .load_val(cfg_addr),
        .adv(rd_acc), .lo(st_q.lo), .hi(st_q.hi), .ptr(rptr), .ptr_nxt(rptr_nxt)
    );

    assign mem_req   = mem_wr || mem_rd;
    assign mem_we    = mem_wr;
    assign mem_addr  = mem_wr ? wptr : rptr;
    assign mem_wdata = wf_head;
    assign eng_we    = st_q.ewe;
    assign eng_addr  = st_q.ea;
    assign eng_data  = st_q.ed;
    assign csr_rdata = csr_sel ? {mode_now, {(30 - MEM_AW){1'b0}}, cfg_hi}
                               : {{(32 - MEM_AW){1'b0}}, cfg_lo};
endmodule

// File: rtl/crc_checker.sv
module crc_checker #(
    parameter int          MEM_AW    = 24,
    parameter logic [31:0] CSR_START = 32'h0000_1000,
    parameter logic [31:0] CSR_END   = 32'h0000_1004
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_valid,
    input logic              host_ready,
    input logic [31:0]       host_addr,
    input logic              host_unbuf,
    input logic              eng_we,
    input logic [31:0]       eng_addr,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              ring_full,
    input logic [MEM_AW-1:0] lo,
    input logic [MEM_AW-1:0] hi,
    input logic [1:0]        mode,
    input logic              all_empty,
    input logic              host_q
);
    logic fire, csr_hit;
    assign fire    = host_valid && host_ready;
    assign csr_hit = (host_addr == CSR_START) || (host_addr == CSR_END);

    AST_OFF_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode == 2'b00 && !csr_hit) |=> (eng_we && eng_addr == $past(host_addr))); // R2

    AST_UNBUF_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && host_unbuf && !csr_hit) |=> (eng_we && eng_addr == $past(host_addr))); // R9

    AST_CSR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && csr_hit) |=> !eng_we); // R9

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_gnt) |-> !ring_full); // R7

    AST_ADDR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && lo < hi) |-> (mem_addr >= lo && mem_addr < hi && mem_addr[2:0] == 3'b000)); // R6

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11); // R11

    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (lo[2:0] == 3'b000 && hi[2:0] == 3'b000)); // R12

    AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && all_empty && !host_q && !(fire && csr_hit)) |=> mode == 2'b00); // R10
endmodule

bind cmd_ring_ctrl crc_checker #(
    .MEM_AW(MEM_AW), .CSR_START(CSR_START), .CSR_END(CSR_END)
) i_crc_checker (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_addr(host_addr), .host_unbuf(host_unbuf), .eng_we(eng_we), .eng_addr(eng_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
    .ring_full(ring_full), .lo(cfg_lo), .hi(cfg_hi), .mode(mode_now),
    .all_empty(all_empty), .host_q(host_q)
);

// File: tb/test_cmd_ring_ctrl.sv
module test_cmd_ring_ctrl;
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [31:0] A_START = 32'h0000_1000;
    localparam logic [31:0] A_END   = 32'h0000_1004;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_valid = 1'b0, host_unbuf = 1'b0, csr_sel = 1'b0, eng_idle = 1'b0;
    logic [31:0] host_addr = '0, host_data = '0;
    logic host_ready, eng_we, mem_req, mem_we;
    logic [31:0] csr_rdata, eng_addr, eng_data;
    logic [23:0] mem_addr;
    logic [63:0] mem_wdata, rd_q;
    logic rv_q = 1'b0;

    int n_chk = 0, n_fail = 0, log_n = 0, mem_wr_n = 0, range_err = 0;
    logic [31:0] log_a [256];
    logic [31:0] log_d [256];
    logic [63:0] mem [256];
    logic [23:0] ring_lo = 24'h000100, ring_hi = 24'h000140;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmd_ring_ctrl i_cmd_ring_ctrl (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
        .host_addr(host_addr), .host_data(host_data), .host_unbuf(host_unbuf),
        .csr_sel(csr_sel), .csr_rdata(csr_rdata), .eng_idle(eng_idle),
        .eng_we(eng_we), .eng_addr(eng_addr), .eng_data(eng_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(1'b1), .mem_rvalid(rv_q), .mem_rdata(rd_q)
    );

    always @(posedge clk) begin
        rv_q <= 1'b0;
        if (rst_n && mem_req) begin
            if (mem_we) begin
                mem[mem_addr[10:3]] <= mem_wdata;
                mem_wr_n++;
                if (mem_addr < ring_lo || mem_addr >= ring_hi) range_err++;
            end else begin
                rv_q <= 1'b1;
                rd_q <= mem[mem_addr[10:3]];
            end
        end
        if (rst_n && eng_we) begin
            log_a[log_n[7:0]] = eng_addr;
            log_d[log_n[7:0]] = eng_data;
            log_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic host_wr(input logic [31:0] a, input logic [31:0] d, input logic u);
        @(negedge clk);
        host_valid = 1'b1; host_addr = a; host_data = d; host_unbuf = u;
        #1;
        while (!host_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 host_valid = 1'b0; host_unbuf = 1'b0;
    endtask

    task automatic rd_csr(input logic s, output logic [31:0] v);
        @(negedge clk);
        csr_sel = s;
        #1 v = csr_rdata;
    endtask

    task automatic expect_direct(input logic [31:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        chk(eng_we && eng_addr == a && eng_data == d, req, {eng_we, eng_addr}, {1'b1, a});
    endtask

    task automatic expect_log(input int base, input int n, input logic [31:0] a0, input string req);
        chk(log_n == base + n, req, log_n, base + n);
        for (int i = 0; i < n; i++)
            chk(log_a[(base + i) % 256] == a0 + i && log_d[(base + i) % 256] == 32'hD000 + a0 + i,
                req, log_a[(base + i) % 256], a0 + i);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        chk(host_ready && !eng_we && !mem_req, "R1 idle outputs", {host_ready, eng_we, mem_req}, 3'b100);
        rd_csr(1'b0, v); chk(v == 0, "R1 start reg", v, 0);
        rd_csr(1'b1, v); chk(v == 0, "R1 end/mode reg", v, 0);
    endtask

    task automatic t_off_pass();
        eng_idle = 1'b0;
        host_wr(32'h20, 32'hA5A5_0001, 1'b0);
        expect_direct(32'h20, 32'hA5A5_0001, "R2 off pass-through");
        chk(mem_wr_n == 0, "R2 no memory", mem_wr_n, 0);
    endtask

    task automatic t_program();
        logic [31:0] v;
        int base;
        wait_cyc(2);
        base = log_n;
        host_wr(A_START, 32'h0000_0100, 1'b0);
        host_wr(A_END, {2'b01, 6'b0, 24'h000140}, 1'b0);
        wait_cyc(3);
        chk(log_n == base, "R9 config writes silent", log_n, base);
        rd_csr(1'b0, v); chk(v == 32'h0000_0100, "R12 start readback", v, 32'h0000_0100);
        rd_csr(1'b1, v); chk(v == 32'h4000_0140, "R12 end readback", v, 32'h4000_0140);
    endtask

    task automatic t_direct_on();
        eng_idle = 1'b1;
        host_wr(32'h24, 32'h1234_5678, 1'b0);
        expect_direct(32'h24, 32'h1234_5678, "R3 idle-empty direct");
        wait_cyc(3);
        chk(mem_wr_n == 0, "R3 no memory write", mem_wr_n, 0);
    endtask

    task automatic t_queue();
        int base;
        eng_idle = 1'b0;
        wait_cyc(2);
        base = log_n;
        for (int i = 0; i < 3; i++) host_wr(32'h30 + i, 32'hD030 + i, 1'b0);
        wait_cyc(10);
        chk(mem_wr_n == 3, "R4 entries to memory", mem_wr_n, 3);
        chk(mem[32] == {32'hD030, 32'h30}, "R4 entry format", mem[32], {32'hD030, 32'h30});
        chk(mem[34] == {32'hD032, 32'h32}, "R4 third entry slot", mem[34], {32'hD032, 32'h32});
        chk(log_n == base, "R4 engine untouched", log_n, base);
        eng_idle = 1'b1;
        wait_cyc(12);
        expect_log(base, 3, 32'h30, "R5 drain order");
    endtask

    task automatic t_unbuf();
        int base;
        eng_idle = 1'b0;
        wait_cyc(2);
        base = log_n;
        host_wr(32'h40, 32'hD040, 1'b0);
        host_wr(32'h44, 32'hBEEF, 1'b1);
        expect_direct(32'h44, 32'hBEEF, "R9 unbufferable immediate");
        eng_idle = 1'b1;
        wait_cyc(10);
        chk(log_n == base + 2 && log_a[(base + 1) % 256] == 32'h40, "R9 queued after unbuf",
            log_a[(base + 1) % 256], 32'h40);
    endtask

    task automatic t_full_wrap();
        int base, w0;
        eng_idle = 1'b0;
        wait_cyc(2);
        base = log_n;
        w0 = mem_wr_n;
        for (int i = 0; i < 15; i++) host_wr(32'h100 + i, 32'hD100 + i, 1'b0);
        wait_cyc(20);
        @(negedge clk);
        host_valid = 1'b1; host_addr = 32'h10F; host_data = 32'hD10F;
        #1 chk(!host_ready, "R7 stall when full", host_ready, 0);
        host_valid = 1'b0;
        chk(log_n == base, "R7 nothing drained yet", log_n, base);
        eng_idle = 1'b1;
        host_wr(32'h10F, 32'hD10F, 1'b0);
        wait_cyc(60);
        expect_log(base, 16, 32'h100, "R5 R7 order after full");
        chk(range_err == 0, "R6 addresses in ring", range_err, 0);
        chk(mem_wr_n - w0 >= 5, "R6 pointer wrapped", mem_wr_n - w0, 5);
    endtask

    task automatic t_restart();
        int base;
        eng_idle = 1'b0;
        wait_cyc(2);
        base = log_n;
        host_wr(32'h50, 32'hD050, 1'b0);
        host_wr(32'h51, 32'hD051, 1'b0);
        wait_cyc(10);
        host_wr(A_START, 32'h0000_0100, 1'b0);
        eng_idle = 1'b1;
        wait_cyc(10);
        chk(log_n == base, "R8 queued discarded", log_n, base);
        host_wr(32'h58, 32'hD058, 1'b0);
        expect_direct(32'h58, 32'hD058, "R8 ring empty after restart");
    endtask

    task automatic t_flush();
        logic [31:0] v;
        int base;
        eng_idle = 1'b0;
        wait_cyc(2);
        base = log_n;
        for (int i = 0; i < 3; i++) host_wr(32'h60 + i, 32'hD060 + i, 1'b0);
        host_wr(A_END, {2'b10, 6'b0, 24'h000140}, 1'b0);
        rd_csr(1'b1, v); chk(v == 32'h8000_0140, "R10 flush mode held", v, 32'h8000_0140);
        eng_idle = 1'b1;
        wait_cyc(20);
        expect_log(base, 3, 32'h60, "R10 flush drains in order");
        rd_csr(1'b1, v); chk(v == 32'h0000_0140, "R10 reverts to off", v, 32'h0000_0140);
        eng_idle = 1'b0;
        host_wr(32'h70, 32'hD070, 1'b0);
        expect_direct(32'h70, 32'hD070, "R2 off after flush");
    endtask

    task automatic t_fields();
        logic [31:0] v;
        host_wr(A_END, {2'b01, 6'b0, 24'h000140}, 1'b0);
        host_wr(A_END, {2'b11, 6'b0, 24'h000140}, 1'b0);
        rd_csr(1'b1, v); chk(v == 32'h4000_0140, "R11 mode 11 ignored", v, 32'h4000_0140);
        host_wr(A_START, 32'hFFFF_FFFF, 1'b0);
        rd_csr(1'b0, v); chk(v == 32'h00FF_FFF8, "R12 start reserved/align", v, 32'h00FF_FFF8);
        host_wr(A_END, 32'hFFFF_FFFF, 1'b0);
        rd_csr(1'b1, v); chk(v == 32'h40FF_FFF8, "R11 R12 end reserved/align", v, 32'h40FF_FFF8);
    endtask

    initial begin
        wait_cyc(4);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_off_pass();
        t_program();
        t_direct_on();
        t_queue();
        t_unbuf();
        t_full_wrap();
        t_restart();
        t_flush();
        t_fields();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule